// File: doc/BRIEF.md
# Rotate-Left Field Mask Unit

This unit takes a 32-bit source word, rotates it left by an amount from 0 to 31, and then keeps only the bits that fall inside a contiguous field. The field is given by a first bit and a last bit, with bit 0 being the most significant bit. When the first bit is numbered higher than the last bit, the field wraps around the ends of the word. The amount comes either from a 5-bit immediate or from the low five bits of a 32-bit register operand.

There are two merge modes. In clearing mode, every bit outside the field is zero. In insert mode, every bit outside the field keeps the value of a destination word supplied with the request. Many common operations are special cases of this one operation:

- Logical left and right shifts. A right shift by n is a left rotation by 32−n with a matching field.
- Plain rotation.
- Field extraction to either end of the word.
- Clearing a single bit.
- Inserting a bit field into an existing word.

The result is registered one cycle after a valid request. Three sign flags come with it and compare the result, read as a signed number, against zero.

Top module: `rotmask_unit`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `out_valid`, `out_result`, `out_lt`, `out_gt` and `out_eq` are all zero.
- R2: `out_valid` is high in exactly the cycle after a clock edge that sampled `in_valid` high, and its result reflects the inputs sampled at that edge.
- R3: A field from bit 0 to bit 31 returns the source rotated left by the amount, with no bit lost.
- R4: In clearing mode with first ≤ last, the result bits whose MSB-first positions lie from first to last equal the rotated source, and all other bits are zero. This gives shifts (rotate 2, field 0..29, is shift left by 2; rotate 30, field 2..31, is logical shift right by 2) and extraction to either end of the word.
- R5: When first > last, the field is every position ≤ last together with every position ≥ first. With rotate 0 and an all-ones source, field 6..4 clears only MSB-first bit 5 (result 0xFBFFFFFF), and field 5..5 keeps only that bit (result 0x04000000).
- R6: When `in_insert` is 1, bits outside the field take the value of `in_dst` instead of zero. Rotate 30 with field 2..8 places the source's top 7 bits at MSB-first positions 2..8.
- R7: When `in_use_reg` is 1, the amount is `in_reg_amt[4:0]`, and bits 31..5 of that operand have no effect. When `in_use_reg` is 0, the amount is `in_imm_amt`.
- R8: With a valid result, exactly one flag is set: `out_lt` when bit 31 of the result is 1, `out_eq` when the result is zero, and `out_gt` otherwise.
- R9: While `in_valid` is low, `out_result` and the flags hold their last value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_insert | input | 1 | 1 selects insert mode, 0 selects clearing mode |
| in_use_reg | input | 1 | 1 takes the amount from `in_reg_amt`, 0 from `in_imm_amt` |
| in_imm_amt | input | 5 | Immediate rotate amount |
| in_reg_amt | input | 32 | Register rotate operand; only the low 5 bits are used |
| in_first | input | 5 | First field bit, MSB-first numbering |
| in_last | input | 5 | Last field bit, MSB-first numbering |
| in_src | input | 32 | Word to rotate |
| in_dst | input | 32 | Destination word merged in insert mode |
| out_valid | output | 1 | Result valid |
| out_result | output | 32 | Registered result |
| out_lt | output | 1 | Result is negative |
| out_gt | output | 1 | Result is positive and non-zero |
| out_eq | output | 1 | Result is zero |

## Verification
Two functions can act in the same cycle: the wrap of the field, and the insert merge. A wrapped field in insert mode must take the middle run of bits from the destination and both outer runs from the rotated source.

The bench provokes this overlap directly, with complementary source and destination patterns. It then sweeps all 1024 first/last pairs, alternating the mode. Every result is compared against a bit-by-bit model that is written from the field definition.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
  typedef enum logic {
    MERGE_CLEAR  = 1'b0,
    MERGE_INSERT = 1'b1
  } merge_mode_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } sign_flags_t;
endpackage

// File: rtl/rml_rotator.sv
module rml_rotator #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  src_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-1:0]  rot_o
);
  logic [W-1:0] stage [0:SW];
  assign stage[0] = src_i;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stage[s+1] = amt_i[s] ? {stage[s][W-1-SH:0], stage[s][W-1 -: SH]}
                                 : stage[s];
  end

  assign rot_o = stage[SW];
endmodule

// File: rtl/rml_mask_gen.sv
module rml_mask_gen #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [SW-1:0] first_i,
  input  logic [SW-1:0] last_i,
  output logic [W-1:0]  mask_o
);
  logic wrap;
  assign wrap = first_i > last_i;

  // vector index k holds MSB-first position W-1-k
  for (genvar k = 0; k < W; k++) begin : g_bit
    localparam logic [SW-1:0] POS = SW'(W - 1 - k);
    assign mask_o[k] = wrap ? ((POS >= first_i) || (POS <= last_i))
                            : ((POS >= first_i) && (POS <= last_i));
  end

  always_comb begin
    if (first_i == last_i) begin
      a_r5_single_bit: assert ($countones(mask_o) == 1)
        else $error("single-bit field has wrong population");
    end
    if (wrap) begin
      // R5: a wrapped field leaves exactly first-last-1 positions clear
      a_r5_wrap_count: assert ($countones(mask_o) ==
                               W - (int'(first_i) - int'(last_i) - 1))
        else $error("wrapped field has wrong population");
    end
  end
endmodule

// File: rtl/rml_sign_flags.sv
module rml_sign_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0]              val_i,
  output rotmask_pkg::sign_flags_t  flags_o
);
  always_comb begin
    flags_o.eq = (val_i == '0);
    flags_o.lt = val_i[W-1];
    flags_o.gt = !val_i[W-1] && (val_i != '0);
  end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit #(
  parameter int W  = 32,
  localparam int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_insert,
  input  logic          in_use_reg,
  input  logic [SW-1:0] in_imm_amt,
  input  logic [W-1:0]  in_reg_amt,
  input  logic [SW-1:0] in_first,
  input  logic [SW-1:0] in_last,
  input  logic [W-1:0]  in_src,
  input  logic [W-1:0]  in_dst,
  output logic          out_valid,
  output logic [W-1:0]  out_result,
  output logic          out_lt,
  output logic          out_gt,
  output logic          out_eq
);
  import rotmask_pkg::*;

  merge_mode_e  mode;
  logic [SW-1:0] amt;
  logic [W-1:0]  rotated;
  logic [W-1:0]  mask;
  logic [W-1:0]  merged;
  sign_flags_t   flags_nxt;

  assign mode = merge_mode_e'(in_insert);
  assign amt  = in_use_reg ? in_reg_amt[SW-1:0] : in_imm_amt;

  rml_rotator #(.W(W), .SW(SW)) u_rot (
    .src_i (in_src),
    .amt_i (amt),
    .rot_o (rotated)
  );

  rml_mask_gen #(.W(W), .SW(SW)) u_mask (
    .first_i (in_first),
    .last_i  (in_last),
    .mask_o  (mask)
  );

  always_comb begin
    merged = rotated & mask;
    if (mode == MERGE_INSERT) merged = merged | (in_dst & ~mask);
  end

  rml_sign_flags #(.W(W)) u_flags (
    .val_i   (merged),
    .flags_o (flags_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_lt     <= 1'b0;
      out_gt     <= 1'b0;
      out_eq     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= merged;
        out_lt     <= flags_nxt.lt;
        out_gt     <= flags_nxt.gt;
        out_eq     <= flags_nxt.eq;
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid) else $error("valid not propagated");
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid) else $error("spurious valid");
  a_r4_clear_outside: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_insert) |=> ((out_result & ~$past(mask)) == '0))
    else $error("bits outside field not cleared");
  a_r6_keep_dst: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_insert) |=> (((out_result ^ $past(in_dst)) & ~$past(mask)) == '0))
    else $error("destination bits not kept");
  a_r8_one_flag: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones({out_lt, out_gt, out_eq}) == 1))
    else $error("flags not exclusive");
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_result) && $stable({out_lt, out_gt, out_eq})))
    else $error("result changed without request");
endmodule

// File: tb/rotmask_unit_bench.sv
module rotmask_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_insert, in_use_reg;
  logic [4:0]  in_imm_amt, in_first, in_last;
  logic [31:0] in_reg_amt, in_src, in_dst;
  logic        out_valid, out_lt, out_gt, out_eq;
  logic [31:0] out_result;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rotmask_unit u_rotmask_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insert(in_insert),
    .in_use_reg(in_use_reg), .in_imm_amt(in_imm_amt), .in_reg_amt(in_reg_amt),
    .in_first(in_first), .in_last(in_last), .in_src(in_src), .in_dst(in_dst),
    .out_valid(out_valid), .out_result(out_result),
    .out_lt(out_lt), .out_gt(out_gt), .out_eq(out_eq)
  );

  function automatic logic [31:0] model(input logic [31:0] s, input logic [31:0] d,
                                        input int amt, input int f, input int l,
                                        input bit ins);
    logic [31:0] r, res;
    for (int p = 0; p < 32; p++) begin
      // MSB-first position p of the rotated word comes from position (p+amt)%32
      r[31-p] = s[31 - ((p + amt) % 32)];
    end
    for (int p = 0; p < 32; p++) begin
      bit inside_f;
      if (f <= l) inside_f = (p >= f) && (p <= l);
      else        inside_f = !((p > l) && (p < f));
      res[31-p] = inside_f ? r[31-p] : (ins ? d[31-p] : 1'b0);
    end
    return res;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] s, input logic [31:0] d, input int amt,
                        input int f, input int l, input bit ins);
    @(negedge clk);
    in_valid = 1'b1; in_insert = ins; in_use_reg = 1'b0;
    in_imm_amt = 5'(amt); in_src = s; in_dst = d;
    in_first = 5'(f); in_last = 5'(l);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b1; in_insert = 1'b0; in_use_reg = 1'b0;
    in_imm_amt = 5'd3; in_reg_amt = '0; in_first = 0; in_last = 31;
    in_src = 32'hFFFF_FFFF; in_dst = '0;
    repeat (3) @(negedge clk);
    check("R1 result", out_result, 32'h0);
    check("R1 valid+flags", {31'b0, out_valid | out_lt | out_gt | out_eq}, 32'h0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_rotate;
    run_op(32'hABCD_EF01, '0, 4, 0, 31, 1'b0);
    check("R3 rotate4", out_result, 32'hBCDE_F01A);
    check("R2 valid", {31'b0, out_valid}, 32'h1);
    @(negedge clk);
    check("R2 valid drop", {31'b0, out_valid}, 32'h0);
  endtask

  task automatic t_shifts;
    run_op(32'h8000_0001, '0, 2, 0, 29, 1'b0);
    check("R4 shl2", out_result, 32'h0000_0004);
    run_op(32'h8000_0003, '0, 30, 2, 31, 1'b0);
    check("R4 shr2", out_result, 32'h2000_0000);
  endtask

  task automatic t_extract;
    run_op(32'hABCD_EF01, '0, 4, 0, 6, 1'b0);
    check("R4 extract high", out_result, 32'hBC00_0000);
    run_op(32'hABCD_EF01, '0, 11, 25, 31, 1'b0);
    check("R4 extract low", out_result, 32'h0000_005E);
  endtask

  task automatic t_wrap;
    run_op(32'hFFFF_FFFF, '0, 0, 6, 4, 1'b0);
    check("R5 clear bit5", out_result, 32'hFBFF_FFFF);
    run_op(32'hFFFF_FFFF, '0, 0, 5, 5, 1'b0);
    check("R5 keep bit5", out_result, 32'h0400_0000);
  endtask

  task automatic t_insert;
    run_op(32'h0000_0000, 32'hFFFF_FFFF, 30, 2, 8, 1'b1);
    check("R6 insert zeros", out_result, 32'hC07F_FFFF);
    run_op(32'hFE00_0000, 32'h0000_0000, 30, 2, 8, 1'b1);
    check("R6 insert ones", out_result, 32'h3F80_0000);
    // wrap and insert together: middle run from dst, outer runs from source
    run_op(32'hFFFF_FFFF, 32'h0000_0000, 0, 20, 9, 1'b1);
    check("R6 wrap insert", out_result, model(32'hFFFF_FFFF, 0, 0, 20, 9, 1'b1));
  endtask

  task automatic t_reg_amt;
    @(negedge clk);
    in_valid = 1'b1; in_insert = 1'b0; in_use_reg = 1'b1;
    in_reg_amt = 32'hFFFF_FFE4; in_imm_amt = 5'd9;
    in_src = 32'hABCD_EF01; in_first = 0; in_last = 31;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 reg amount low bits", out_result, 32'hBCDE_F01A);
    run_op(32'hABCD_EF01, '0, 9, 0, 31, 1'b0);
    check("R7 imm amount", out_result, model(32'hABCD_EF01, 0, 9, 0, 31, 1'b0));
  endtask

  task automatic t_flags;
    run_op(32'h0000_0000, '0, 0, 0, 31, 1'b0);
    check("R8 eq", {29'b0, out_lt, out_gt, out_eq}, 32'h1);
    run_op(32'h8000_0000, '0, 0, 0, 31, 1'b0);
    check("R8 lt", {29'b0, out_lt, out_gt, out_eq}, 32'h4);
    run_op(32'h0000_0001, '0, 0, 0, 31, 1'b0);
    check("R8 gt", {29'b0, out_lt, out_gt, out_eq}, 32'h2);
  endtask

  task automatic t_hold;
    run_op(32'h1234_5678, '0, 8, 0, 31, 1'b0);
    in_src = 32'hFFFF_FFFF; in_dst = 32'h5555_5555; in_insert = 1'b1;
    in_first = 3; in_last = 1;
    repeat (3) @(negedge clk);
    check("R9 hold result", out_result, 32'h3456_7812);
    check("R9 hold flags", {29'b0, out_lt, out_gt, out_eq}, 32'h2);
  endtask

  task automatic t_sweep;
    for (int f = 0; f < 32; f++) begin
      for (int l = 0; l < 32; l++) begin
        logic [31:0] s, d;
        int amt;
        s = 32'h9E37_79B9 ^ (f * 32'h0101_0101) ^ (l << 7);
        d = ~s ^ (l * 32'h0011_0011);
        amt = (f * 7 + l * 3) % 32;
        run_op(s, d, amt, f, l, ((f + l) % 2) == 1);
        check((f > l) ? "R5 sweep" : "R4 sweep", out_result,
              model(s, d, amt, f, l, ((f + l) % 2) == 1));
      end
    end
  endtask

  initial begin
    t_reset;
    t_rotate;
    t_shifts;
    t_extract;
    t_wrap;
    t_insert;
    t_reg_amt;
    t_flags;
    t_hold;
    t_sweep;
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule